// File: doc/BRIEF.md
# Dual-Style Parallel Host Register Bus

This block lets a host processor reach a byte-wide register file over a parallel bus. The address and data buses are separate: the address is 11 bits wide and the data bus is an 8-bit bidirectional bus. A static style pin selects one of two host bus conventions. In the first, a chip select and one data strobe qualify the access, and a direction line says whether it is a read or a write. In the second, a chip select is paired with two separate active-low strobes, one for reads and one for writes.

All host control lines are asynchronous to the internal clock and pass through synchronizer chains. Each access the host starts becomes exactly one single-cycle internal read or write pulse. The address, and the data on a write, are latched when the pulse is issued. On a read, the register file answers during the pulse cycle. The block then drives that byte onto the host data bus for as long as the synchronized read access lasts, and leaves the bus floating at all other times.

Top module: `hostbus_par_if`

## Requirements
- R1: With the style latched as 0, an access is cs_n_i low together with ds_n_i low. rw_i high makes it a read (reg_rd_o pulse) and rw_i low makes it a write (reg_wr_o pulse).
- R2: With the style latched as 1, cs_n_i low with rd_n_i low and wr_n_i high is a read. cs_n_i low with wr_n_i low and rd_n_i high is a write.
- R3: With the style latched as 1, holding rd_n_i and wr_n_i low together yields no pulse and leaves the register file untouched. reg_rd_o and reg_wr_o are never high in the same cycle.
- R4: While cs_n_i is high, no strobe combination produces a pulse in either style.
- R5: Each access produces exactly one pulse, one clock wide, however long the host holds it.
- R6: With SYNC_STAGES=2, a pulse is high in the cycle after the third rising clock edge following the assertion of the access inputs.
- R7: In a write-pulse cycle, reg_addr_o holds the address bus value and reg_wdata_o holds the data bus value. reg_addr_o changes only on a pulse and reg_wdata_o changes only on a write pulse.
- R8: A read presents reg_addr_o during the pulse and captures reg_rdata_i in that cycle. The block drives the captured byte onto data_io from the next cycle until the synchronized access ends, and leaves data_io high-impedance otherwise. The bus only rises to driven right after a read pulse.
- R9: style_i is sampled on the first clock after reset is released. Later changes have no effect until the next reset.
- R10: During and right after reset, reg_rd_o and reg_wr_o are 0, reg_addr_o and reg_wdata_o are 0, and data_io is not driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| style_i | input | 1 | Bus style select: 0 strobe plus direction, 1 split read/write strobes |
| cs_n_i | input | 1 | Active-low chip select |
| ds_n_i | input | 1 | Active-low data strobe (style 0) |
| rw_i | input | 1 | Direction, 1 read, 0 write (style 0) |
| rd_n_i | input | 1 | Active-low read strobe (style 1) |
| wr_n_i | input | 1 | Active-low write strobe (style 1) |
| addr_i | input | ADDR_W | Host address bus |
| data_io | inout | DATA_W | Host bidirectional data bus |
| reg_addr_o | output | ADDR_W | Latched register address |
| reg_wdata_o | output | DATA_W | Latched write data |
| reg_wr_o | output | 1 | Single-cycle register write pulse |
| reg_rd_o | output | 1 | Single-cycle register read pulse |
| reg_rdata_i | input | DATA_W | Read data from the register file |

## Verification
The bench builds the block with its defaults: an 11-bit address, an 8-bit data bus and two synchronizer stages. These values let it touch both ends of the address range and check the three-edge pulse latency exactly. The bench places a pull-up on the data bus, so a floating bus reads as all ones. That makes the driven and released phases of a read visible.

// File: rtl/hostbus_pkg.sv
package hostbus_pkg;

    typedef enum logic {
        STYLE_STROBE_DIR = 1'b0,
        STYLE_SPLIT      = 1'b1
    } bus_style_e;

    typedef struct packed {
        logic cs_n;
        logic ds_n;
        logic rw;
        logic rd_n;
        logic wr_n;
    } host_ctrl_t;

    localparam int CTRL_W = $bits(host_ctrl_t);
    localparam host_ctrl_t CTRL_IDLE = '{cs_n: 1'b1, ds_n: 1'b1, rw: 1'b1,
                                         rd_n: 1'b1, wr_n: 1'b1};

endpackage

// File: rtl/hostbus_sync.sv
module hostbus_sync #(
    parameter int               WIDTH   = 5,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [WIDTH-1:0] chain_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        logic [WIDTH-1:0] src;
        if (s == 0) begin : g_first
            assign src = d_i;
        end else begin : g_next
            assign src = chain_q[s-1];
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[s] <= RST_VAL;
            else        chain_q[s] <= src;
        end
    end

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/hostbus_decode.sv
module hostbus_decode
    import hostbus_pkg::*;
(
    input  bus_style_e style_i,
    input  logic       enable_i,
    input  host_ctrl_t ctrl_i,
    output logic       rd_act_o,
    output logic       wr_act_o
);
    logic sel;

    always_comb begin
        sel      = 1'b0;
        rd_act_o = 1'b0;
        wr_act_o = 1'b0;
        case (style_i)
            STYLE_STROBE_DIR: begin
                sel      = !ctrl_i.cs_n && !ctrl_i.ds_n;
                rd_act_o = sel && ctrl_i.rw;
                wr_act_o = sel && !ctrl_i.rw;
            end
            STYLE_SPLIT: begin
                sel      = !ctrl_i.cs_n;
                rd_act_o = sel && !ctrl_i.rd_n && ctrl_i.wr_n;
                wr_act_o = sel && !ctrl_i.wr_n && ctrl_i.rd_n;
            end
            default: ;
        endcase
        rd_act_o = rd_act_o && enable_i;
        wr_act_o = wr_act_o && enable_i;
    end
endmodule

// File: rtl/hostbus_par_if.sv
module hostbus_par_if
    import hostbus_pkg::*;
#(
    parameter int ADDR_W      = 11,
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              style_i,
    input  logic              cs_n_i,
    input  logic              ds_n_i,
    input  logic              rw_i,
    input  logic              rd_n_i,
    input  logic              wr_n_i,
    input  logic [ADDR_W-1:0] addr_i,
    inout  wire  [DATA_W-1:0] data_io,
    output logic [ADDR_W-1:0] reg_addr_o,
    output logic [DATA_W-1:0] reg_wdata_o,
    output logic              reg_wr_o,
    output logic              reg_rd_o,
    input  logic [DATA_W-1:0] reg_rdata_i
);
    typedef struct packed {
        logic              lock;
        bus_style_e        style;
        logic              rd_act;
        logic              wr_act;
        logic              rd_pls;
        logic              wr_pls;
        logic              oe;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic [DATA_W-1:0] rdata;
    } bus_state_t;

    localparam bus_state_t ST_RESET = '{
        lock: 1'b0, style: STYLE_STROBE_DIR, rd_act: 1'b0, wr_act: 1'b0,
        rd_pls: 1'b0, wr_pls: 1'b0, oe: 1'b0,
        addr: '0, wdata: '0, rdata: '0};

    host_ctrl_t ctrl_raw, ctrl_sync;
    logic       rd_act, wr_act;
    bus_state_t st_d, st_q;

    // Signals observed by the bound checker
    logic       bus_oe;
    logic       style_q;
    logic       lock_q;

    assign ctrl_raw = '{cs_n: cs_n_i, ds_n: ds_n_i, rw: rw_i,
                        rd_n: rd_n_i, wr_n: wr_n_i};

    hostbus_sync #(
        .WIDTH  (CTRL_W),
        .STAGES (SYNC_STAGES),
        .RST_VAL(CTRL_IDLE)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d_i  (ctrl_raw),
        .q_o  (ctrl_sync)
    );

    hostbus_decode u_decode (
        .style_i (st_q.style),
        .enable_i(st_q.lock),
        .ctrl_i  (ctrl_sync),
        .rd_act_o(rd_act),
        .wr_act_o(wr_act)
    );

    always_comb begin
        st_d = st_q;
        if (!st_q.lock) begin
            st_d.lock  = 1'b1;
            st_d.style = bus_style_e'(style_i);
        end
        st_d.rd_act = rd_act;
        st_d.wr_act = wr_act;
        st_d.rd_pls = rd_act && !st_q.rd_act;
        st_d.wr_pls = wr_act && !st_q.wr_act;
        if (st_d.rd_pls || st_d.wr_pls) st_d.addr  = addr_i;
        if (st_d.wr_pls)                st_d.wdata = data_io;
        if (st_q.rd_pls)                st_d.rdata = reg_rdata_i;
        st_d.oe = rd_act && (st_q.oe || st_q.rd_pls);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_RESET;
        else        st_q <= st_d;
    end

    assign data_io     = st_q.oe ? st_q.rdata : {DATA_W{1'bz}};
    assign reg_addr_o  = st_q.addr;
    assign reg_wdata_o = st_q.wdata;
    assign reg_wr_o    = st_q.wr_pls;
    assign reg_rd_o    = st_q.rd_pls;

    assign bus_oe  = st_q.oe;
    assign style_q = st_q.style;
    assign lock_q  = st_q.lock;
endmodule

// File: rtl/hostbus_par_chk.sv
module hostbus_par_chk #(
    parameter int AW = 11,
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          reg_rd_o,
    input logic          reg_wr_o,
    input logic [AW-1:0] reg_addr_o,
    input logic [DW-1:0] reg_wdata_o,
    input logic          bus_oe,
    input logic          style_q,
    input logic          lock_q
);
    p_rd_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd_o |=> !reg_rd_o);

    p_wr_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_o |=> !reg_wr_o);

    p_excl_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_rd_o && reg_wr_o));

    p_addr_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_rd_o || reg_wr_o) |-> $stable(reg_addr_o));

    p_wdata_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_wr_o |-> $stable(reg_wdata_o));

    p_drive_after_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_oe) |-> $past(reg_rd_o));

    p_style_static_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(lock_q) |-> $stable(style_q));
endmodule

bind hostbus_par_if hostbus_par_chk #(.AW(ADDR_W), .DW(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_rd_o   (reg_rd_o),
    .reg_wr_o   (reg_wr_o),
    .reg_addr_o (reg_addr_o),
    .reg_wdata_o(reg_wdata_o),
    .bus_oe     (bus_oe),
    .style_q    (style_q),
    .lock_q     (lock_q)
);

// File: tb/tb_hostbus_par_if.sv
module tb_hostbus_par_if;
    localparam int AW = 11;
    localparam int DW = 8;
    localparam int NV = 11;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic style = 1'b0;
    logic cs_n = 1'b1, ds_n = 1'b1, rw = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] tb_dq = '0;
    logic          tb_oe = 1'b0;
    tri   [DW-1:0] data_bus;
    logic [AW-1:0] reg_addr;
    logic [DW-1:0] reg_wdata;
    logic          reg_wr, reg_rd;
    logic [DW-1:0] reg_rdata;

    logic [DW-1:0] mem [2**AW];
    int rd_cnt = 0, wr_cnt = 0;
    logic [AW-1:0] last_addr = '0;
    logic [DW-1:0] last_wdata = '0;
    logic [DW-1:0] bus_mid;
    int n_chk = 0, n_fail = 0;

    always #10 clk = ~clk;

    assign data_bus = tb_oe ? tb_dq : {DW{1'bz}};
    for (genvar i = 0; i < DW; i++) begin : g_pu
        pullup (data_bus[i]);
    end

    hostbus_par_if dut (
        .clk(clk), .rst_n(rst_n), .style_i(style),
        .cs_n_i(cs_n), .ds_n_i(ds_n), .rw_i(rw), .rd_n_i(rd_n), .wr_n_i(wr_n),
        .addr_i(addr), .data_io(data_bus),
        .reg_addr_o(reg_addr), .reg_wdata_o(reg_wdata),
        .reg_wr_o(reg_wr), .reg_rd_o(reg_rd), .reg_rdata_i(reg_rdata)
    );

    // Bench register file: combinational read, written on write pulses
    assign reg_rdata = mem[reg_addr];
    always @(posedge clk) begin
        if (reg_wr) begin
            mem[reg_addr] <= reg_wdata;
            wr_cnt        <= wr_cnt + 1;
            last_addr     <= reg_addr;
            last_wdata    <= reg_wdata;
        end
        if (reg_rd) begin
            rd_cnt    <= rd_cnt + 1;
            last_addr <= reg_addr;
        end
    end

    // {style, is_read, address, data (write value or expected read value)}
    localparam logic [20:0] VEC [NV] = '{
        {1'b0, 1'b0, 11'h000, 8'hA5},
        {1'b0, 1'b0, 11'h7FF, 8'h5A},
        {1'b0, 1'b0, 11'h123, 8'h3C},
        {1'b0, 1'b1, 11'h000, 8'hA5},
        {1'b0, 1'b1, 11'h7FF, 8'h5A},
        {1'b0, 1'b1, 11'h123, 8'h3C},
        {1'b1, 1'b0, 11'h456, 8'hC3},
        {1'b1, 1'b0, 11'h001, 8'h0F},
        {1'b1, 1'b1, 11'h456, 8'hC3},
        {1'b1, 1'b1, 11'h001, 8'h0F},
        {1'b1, 1'b1, 11'h123, 8'h3C}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic apply_reset(input logic st);
        @(negedge clk);
        rst_n = 1'b0;
        style = st;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic release_bus();
        cs_n = 1'b1; ds_n = 1'b1; rw = 1'b1; rd_n = 1'b1; wr_n = 1'b1;
        tb_oe = 1'b0;
    endtask

    // Drive one access in the given style, hold it, sample the bus mid-way
    task automatic do_access(input logic st, input logic is_rd,
                             input logic [AW-1:0] a, input logic [DW-1:0] d,
                             input int hold);
        @(negedge clk);
        addr  = a;
        tb_dq = d;
        tb_oe = !is_rd;
        cs_n  = 1'b0;
        if (st == 1'b0) begin
            ds_n = 1'b0;
            rw   = is_rd;
        end else begin
            rd_n = !is_rd;
            wr_n = is_rd;
        end
        for (int c = 0; c < hold; c++) begin
            @(negedge clk);
            if (c == 7) bus_mid = data_bus;
        end
        release_bus();
        repeat (6) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog all requirements actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int rd0, wr0;
        for (int i = 0; i < 2**AW; i++) mem[i] = '0;

        // R10: reset state
        repeat (2) @(negedge clk);
        check("R10 rd pulse in reset", 32'(reg_rd), 0);
        check("R10 wr pulse in reset", 32'(reg_wr), 0);
        check("R10 bus floating in reset", 32'(data_bus), 32'hFF);
        apply_reset(1'b0);
        check("R10 addr after reset", 32'(reg_addr), 0);
        check("R10 wdata after reset", 32'(reg_wdata), 0);

        // Vector table: R1 (style 0) and R2 (style 1), R5, R7, R8
        for (int v = 0; v < NV; v++) begin
            logic vs, vr;
            logic [AW-1:0] va;
            logic [DW-1:0] vd;
            {vs, vr, va, vd} = VEC[v];
            if (v > 0 && vs != VEC[v-1][20]) apply_reset(vs);
            rd0 = rd_cnt; wr0 = wr_cnt;
            do_access(vs, vr, va, vd, 10);
            if (vr) begin
                check(vs ? "R2 read pulses" : "R1 read pulses", 32'(rd_cnt - rd0), 1);
                check("R5 no write on read", 32'(wr_cnt - wr0), 0);
                check("R8 read address", 32'(last_addr), 32'(va));
                check("R8 bus driven with data", 32'(bus_mid), 32'(vd));
                check("R8 bus released after read", 32'(data_bus), 32'hFF);
            end else begin
                check(vs ? "R2 write pulses" : "R1 write pulses", 32'(wr_cnt - wr0), 1);
                check("R5 no read on write", 32'(rd_cnt - rd0), 0);
                check("R7 write address", 32'(last_addr), 32'(va));
                check("R7 write data", 32'(last_wdata), 32'(vd));
            end
        end

        // R3: both strobes low in style 1 does nothing
        rd0 = rd_cnt; wr0 = wr_cnt;
        @(negedge clk);
        addr = 11'h456; tb_dq = 8'h99; tb_oe = 1'b1;
        cs_n = 1'b0; rd_n = 1'b0; wr_n = 1'b0;
        repeat (10) @(negedge clk);
        release_bus();
        repeat (6) @(negedge clk);
        check("R3 no pulse with both strobes", 32'(rd_cnt - rd0 + wr_cnt - wr0), 0);
        do_access(1'b1, 1'b1, 11'h456, 8'h00, 10);
        check("R3 register untouched", 32'(bus_mid), 32'hC3);

        // R4: chip select high, style 1
        rd0 = rd_cnt; wr0 = wr_cnt;
        @(negedge clk);
        addr = 11'h001; tb_dq = 8'h77; tb_oe = 1'b1; wr_n = 1'b0;
        repeat (8) @(negedge clk);
        wr_n = 1'b1; tb_oe = 1'b0; rd_n = 1'b0;
        repeat (8) @(negedge clk);
        release_bus();
        repeat (6) @(negedge clk);
        check("R4 no pulse without select style1", 32'(rd_cnt - rd0 + wr_cnt - wr0), 0);

        // R9: style pin changed after reset is ignored
        apply_reset(1'b0);
        style = 1'b1;
        rd0 = rd_cnt; wr0 = wr_cnt;
        do_access(1'b0, 1'b0, 11'h200, 8'h77, 10);
        check("R9 style0 write after pin change", 32'(wr_cnt - wr0), 1);
        do_access(1'b0, 1'b1, 11'h200, 8'h00, 10);
        check("R9 style0 read after pin change", 32'(bus_mid), 32'h77);

        // R4: chip select high, style 0
        rd0 = rd_cnt; wr0 = wr_cnt;
        @(negedge clk);
        ds_n = 1'b0; rw = 1'b0; tb_oe = 1'b1; tb_dq = 8'h11;
        repeat (8) @(negedge clk);
        rw = 1'b1; tb_oe = 1'b0;
        repeat (8) @(negedge clk);
        release_bus();
        repeat (6) @(negedge clk);
        check("R4 no pulse without select style0", 32'(rd_cnt - rd0 + wr_cnt - wr0), 0);

        // R5: long hold gives one pulse
        rd0 = rd_cnt;
        do_access(1'b0, 1'b1, 11'h7FF, 8'h00, 40);
        check("R5 one pulse on long read", 32'(rd_cnt - rd0), 1);

        // R6: pulse timing relative to input assertion
        @(negedge clk);
        addr = 11'h0AA; tb_dq = 8'h66; tb_oe = 1'b1; cs_n = 1'b0; ds_n = 1'b0; rw = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check("R6 no pulse after two edges", 32'(reg_wr), 0);
        @(negedge clk);
        check("R6 pulse after third edge", 32'(reg_wr), 1);
        check("R7 wdata in pulse cycle", 32'(reg_wdata), 32'h66);
        @(negedge clk);
        check("R6 pulse one cycle wide", 32'(reg_wr), 0);
        release_bus();
        repeat (6) @(negedge clk);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule